// File: doc/BRIEF.md
# MDIO Clause 22 Write Engine

This block lets a processor write one management register of an Ethernet PHY by storing a single 32-bit command word. The command word holds the 16-bit value, the register number, the PHY address and a write-enable flag. When the flag is set, the engine sends a complete Clause 22 write frame on the MDC and MDIO pins. A status word reports when the frame has finished.

While a frame is on the wire, the engine takes the shared MDIO pin away from general-purpose use. It returns the pin when the frame ends. A programmable cycle limit turns a transfer that runs too long into an error flag, so software does not have to wait without bound. A command that arrives while a frame is still running is dropped, and a sticky flag records the drop.

Top module: `mdio_write_engine`

## Requirements
- R1: A write frame is 64 bits sent MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register, turnaround 10, then 16 data bits. The command word fields are data in bits 31:16, register in bits 12:8, and PHY address in bits 4:0.
- R2: A command write starts a frame only when command bit 13 is 1. With bit 13 at 0, no frame starts and busy stays 0.
- R3: From the cycle after an accepted command until the frame ends, `mdio_oe` is 1 and `pin_gpio_sel` is 0. At all other times `mdio_oe` is 0 and `pin_gpio_sel` is 1.
- R4: MDC starts low and toggles every `MDC_HALF` system cycles. MDIO changes only when MDC falls, so the PHY samples it on the rising edge.
- R5: Status bit 0 (done) rises exactly 128·`MDC_HALF` cycles after the frame starts. Busy (status bit 1) and done are never 1 together.
- R6: Done clears on a status read (`stat_re`) or on any command write, unless completion happens in the same cycle.
- R7: A command write while busy is ignored. It sets the sticky overrun flag (status bit 3), which clears on a status read.
- R8: If `tmo_limit` is nonzero and the frame has not completed after `tmo_limit` busy cycles, the frame is aborted and timeout (status bit 2) is set instead of done. Completion in the limit's last cycle wins over timeout. A status read or a new launch clears the flag.
- R9: Command bits 7:5 (upper bits of the address field) have no effect on the frame.
- R10: After reset, all status bits are 0, MDC is low, `mdio_oe` is 0 and `pin_gpio_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| stat_re | input | 1 | Status read strobe (clears done, timeout, overrun) |
| tmo_limit | input | TMO_W | Timeout in system cycles, 0 disables |
| stat_flags | output | 4 | {overrun, timeout, busy, done} |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| pin_gpio_sel | output | 1 | Pin-purpose bit: 1 = general-purpose, 0 = MDIO |

## Verification
An accepted command shows as busy, a low MDC and the first preamble bit one clock edge after the strobe is sampled. MDC then toggles every `MDC_HALF` cycles, and done (or timeout) appears at the edge that ends cycle 128·`MDC_HALF` (or cycle `tmo_limit`) of the frame. Flag clears from `stat_re` or `cmd_we` take effect at the next edge. The bench keeps a cycle counter per frame in a behavioural model and compares every output at each falling clock edge, half a period after the registers settle. A separate monitor captures MDIO on every MDC rising edge and compares the 64 captured bits with the frame built from the command.

// File: rtl/mdio_write_engine.sv
module mdio_write_engine #(
  parameter int MDC_HALF = 2,
  parameter int TMO_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  input  logic             stat_re,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [3:0]       stat_flags,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             pin_gpio_sel
);
  localparam int DW    = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam int NBITS = 64;
  localparam int BW    = $clog2(NBITS);

  logic             busy, done, tmo, ovr, mdc_q;
  logic [DW-1:0]    div;
  logic [BW-1:0]    bitn;
  logic [NBITS-1:0] sh;
  logic [TMO_W-1:0] tcnt;

  wire launch = cmd_we & cmd_wdata[13] & ~busy;
  wire tick   = (div == DW'(MDC_HALF - 1));
  wire fall   = busy & tick & mdc_q;
  wire last   = fall & (bitn == BW'(NBITS - 1));
  wire expire = busy & ~last & (tmo_limit != '0) & ((tcnt + TMO_W'(1)) == tmo_limit);

  wire [NBITS-1:0] frame = {32'hFFFF_FFFF, 2'b01, 2'b01, cmd_wdata[4:0],
                            cmd_wdata[12:8], 2'b10, cmd_wdata[31:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      tmo   <= 1'b0;
      ovr   <= 1'b0;
      mdc_q <= 1'b0;
      div   <= '0;
      bitn  <= '0;
      sh    <= '0;
      tcnt  <= '0;
    end else begin
      if (launch) begin
        busy  <= 1'b1;
        sh    <= frame;
        bitn  <= '0;
        div   <= '0;
        mdc_q <= 1'b0;
        tcnt  <= '0;
      end else if (busy) begin
        tcnt <= tcnt + TMO_W'(1);
        if (last || expire) begin
          busy  <= 1'b0;
          mdc_q <= 1'b0;
          div   <= '0;
        end else if (tick) begin
          div   <= '0;
          mdc_q <= ~mdc_q;
          if (mdc_q) begin
            sh   <= {sh[NBITS-2:0], 1'b0};
            bitn <= bitn + BW'(1);
          end
        end else begin
          div <= div + DW'(1);
        end
      end

      if (last)                   done <= 1'b1;
      else if (stat_re || cmd_we) done <= 1'b0;

      if (expire)                 tmo <= 1'b1;
      else if (stat_re || launch) tmo <= 1'b0;

      if (cmd_we && busy)         ovr <= 1'b1;
      else if (stat_re)           ovr <= 1'b0;
    end
  end

  assign stat_flags   = {ovr, tmo, busy, done};
  assign mdc          = mdc_q;
  assign mdio_o       = busy & sh[NBITS-1];
  assign mdio_oe      = busy;
  assign pin_gpio_sel = ~busy;
endmodule

// File: rtl/mdio_write_engine_chk.sv
module mdio_write_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [3:0]  stat_flags,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        pin_gpio_sel
);
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[13] && !stat_flags[1]) |=> stat_flags[1]);

  assert_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_flags[1] && !(cmd_we && cmd_wdata[13])) |=> !stat_flags[1]);

  assert_pin_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flags[1] |-> (mdio_oe && !pin_gpio_sel));

  assert_stable_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));

  assert_done_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_flags[0] && stat_flags[1]));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && stat_flags[1]) |=> stat_flags[3]);
endmodule

bind mdio_write_engine mdio_write_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .stat_flags(stat_flags), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .pin_gpio_sel(pin_gpio_sel)
);

// File: tb/test_mdio_write_engine.sv
`timescale 1ns/1ps
module test_mdio_write_engine;
  localparam int H = 2;
  localparam int T = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        stat_re = 1'b0;
  logic [15:0] tmo_limit = '0;
  logic [3:0]  stat_flags;
  logic        mdc, mdio_o, mdio_oe, pin_gpio_sel;

  always #2.5 clk = ~clk;

  mdio_write_engine #(.MDC_HALF(H), .TMO_W(16)) i_mdio_write_engine (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_re(stat_re), .tmo_limit(tmo_limit), .stat_flags(stat_flags),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .pin_gpio_sel(pin_gpio_sel));

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: PHY side samples on MDC rising edge
  logic [63:0] cap = '0;
  int capn = 0;
  always @(posedge mdc) begin
    cap  = {cap[62:0], mdio_o};
    capn = capn + 1;
  end

  // behavioural reference
  bit m_busy, m_done, m_tmo, m_ovr, fin, ab, st;
  int m_n, m_cap0;
  logic [63:0] m_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_tmo = 0; m_ovr = 0; m_n = 0;
    end else begin
      fin = 0; ab = 0;
      st = cmd_we && cmd_wdata[13] && !m_busy;
      if (m_busy) begin
        if (m_n == T - 1) fin = 1;
        else if (tmo_limit != 0 && m_n + 1 == int'(tmo_limit)) ab = 1;
      end
      if (cmd_we && m_busy) m_ovr = 1; else if (stat_re) m_ovr = 0;
      if (fin) m_done = 1; else if (stat_re || cmd_we) m_done = 0;
      if (ab) m_tmo = 1; else if (stat_re || st) m_tmo = 0;
      if (st) begin
        m_busy = 1; m_n = 0; m_cap0 = capn;
        m_frame = 64'hFFFF_FFFF_0000_0000 | (64'h5 << 28)
                | (64'(cmd_wdata & 32'h1F) << 23)
                | (64'((cmd_wdata >> 8) & 32'h1F) << 18)
                | (64'h2 << 16) | 64'(cmd_wdata >> 16);
      end else if (fin || ab) m_busy = 0;
      else if (m_busy) m_n++;
    end
  end

  bit prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check(stat_flags[1] == m_busy, "R3", "busy", stat_flags[1], m_busy);
      check(mdio_oe == m_busy && pin_gpio_sel == !m_busy, "R3", "pin mux",
            {mdio_oe, pin_gpio_sel}, {m_busy, !m_busy});
      check(mdc == (m_busy ? ((m_n / H) % 2) : 0), "R4", "mdc", mdc,
            m_busy ? ((m_n / H) % 2) : 0);
      check(mdio_o == (m_busy ? m_frame[63 - m_n / (2 * H)] : 1'b0), "R1", "mdio",
            mdio_o, m_busy ? m_frame[63 - m_n / (2 * H)] : 1'b0);
      check(stat_flags[0] == m_done, "R5", "done", stat_flags[0], m_done);
      check(stat_flags[2] == m_tmo, "R8", "timeout", stat_flags[2], m_tmo);
      check(stat_flags[3] == m_ovr, "R7", "overrun", stat_flags[3], m_ovr);
      if (prev_busy && !stat_flags[1] && m_done) begin
        check(capn - m_cap0 == 64, "R1", "captured bit count", capn - m_cap0, 64);
        check(cap == m_frame, "R1", "captured frame", cap, m_frame);
      end
      prev_busy = stat_flags[1];
    end
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0; cmd_wdata = '0;
  endtask

  task automatic rd();
    @(negedge clk); stat_re = 1;
    @(negedge clk); stat_re = 0;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] a, input logic [4:0] r,
                                     input logic [15:0] d, input bit w);
    return {d, 2'b00, w, r, a};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.1;
    check(stat_flags == 4'h0 && !mdc && !mdio_oe && pin_gpio_sel, "R10", "reset state",
          {stat_flags, mdc, mdio_oe, pin_gpio_sel}, 7'b0000001);

    wr(mk(8'd5, 5'd26, 16'h1601, 1));
    idle(T + 4);
    check(stat_flags[0], "R5", "done after frame", stat_flags[0], 1);
    rd();
    check(!stat_flags[0], "R6", "done cleared by read", stat_flags[0], 0);

    wr(mk(8'd1, 5'd0, 16'h3100, 0));
    idle(4);
    check(!stat_flags[1], "R2", "no frame without write bit", stat_flags[1], 0);

    wr(mk(8'hE3, 5'd29, 16'h7058, 1));
    idle(10);
    wr(mk(8'd2, 5'd30, 16'h0018, 1));
    check(stat_flags[3], "R7", "overrun set", stat_flags[3], 1);
    idle(T);
    check(stat_flags[0], "R9", "frame with high address bits done", stat_flags[0], 1);
    wr(mk(8'd0, 5'd0, 16'h0, 0));
    check(!stat_flags[0], "R6", "done cleared by command", stat_flags[0], 0);
    rd();
    check(!stat_flags[3], "R7", "overrun cleared by read", stat_flags[3], 0);

    tmo_limit = 16'd100;
    wr(mk(8'd0, 5'd22, 16'h052F, 1));
    idle(110);
    check(stat_flags[2] && !stat_flags[0] && pin_gpio_sel, "R8", "timeout abort",
          stat_flags, 4'b0100);
    rd();
    check(!stat_flags[2], "R8", "timeout cleared by read", stat_flags[2], 0);

    tmo_limit = 16'(T);
    wr(mk(8'd4, 5'd17, 16'h0FE0, 1));
    idle(T + 4);
    check(stat_flags[0] && !stat_flags[2], "R8", "completion beats limit",
          stat_flags, 4'b0001);
    tmo_limit = '0;
    rd();

    wr(mk(8'd31, 5'd31, 16'hA5C3, 1));
    idle(T + 4);
    check(stat_flags[0], "R5", "last frame done", stat_flags[0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule